// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block is a slave on a two-wire serial bus (clock line plus open-drain data line). A system clock runs much faster than the bus clock and oversamples both lines. From the synchronized copies the block finds start and stop conditions and the rising and falling edges of the bus clock. It selects itself when the address byte carries the fixed prefix 1010 followed by three strap bits. After a write-address byte it takes a two-byte word address, then any number of data bytes.

Reads come from a register-held byte array. One word pointer is shared by reads and writes. A read with no preceding address returns the byte after the one last touched. A random read is a write of the word address alone, then a repeated start and a read address byte. Reads run on sequentially while the master acknowledges, and they wrap from the top of the array to zero. Each received data byte leaves the block on a one-cycle write strobe with its address, for a separate page-write and commit stage. The same strobe also updates the internal array, so later reads see the new data.

Top module: `twi_byte_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start. It cancels any transfer in progress, even in the middle of a byte, releases the data line, and makes the next eight clocked bits an address byte.
- R2: A rising data line while the clock line is high is a stop. It returns the block to idle and releases the data line. A data byte cut short by a stop produces no write strobe and leaves the word pointer unchanged.
- R3: An address byte whose upper four bits are 1010 and whose bits 3..1 equal `strap_i` is acknowledged: the data line is held low through the ninth clock.
- R4: An address byte that does not match is not acknowledged. Every later byte is then ignored, with no acknowledge and no write strobe, until the next start.
- R5: When bit 0 of the address byte is 0, the next two bytes form the word address, high byte first, and only its low ADDR_W bits are kept. Each following data byte is acknowledged and produces one single-cycle `wr_stb_o` carrying the current pointer and the byte. The pointer then advances by one, modulo 2^ADDR_W.
- R6: An address byte with bit 0 set, sent without a preceding word address, returns the byte at the last accessed address plus one.
- R7: Writing only a word address, then a repeated start and a read address byte, returns the byte stored at that word address.
- R8: During a read, the pointer advances after every byte sent. While the master acknowledges, the next byte follows, and the pointer wraps from 2^ADDR_W-1 to 0.
- R9: If the master does not acknowledge a read byte, the block releases the data line and drives nothing until the next start.
- R10: The data line output changes only after a falling edge of the clock line. It never changes while the clock line stays high.
- R11: Bits are taken on the rising clock edge, most significant bit first. Read data is shifted out most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| strap_i | input | 3 | Address strap bits compared with address bits 3..1 |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| wr_stb_o | output | 1 | One-cycle strobe per received data byte |
| wr_addr_o | output | ADDR_W | Word address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |

## Verification
The bench builds the block with ADDR_W = 6, which gives a 64-byte array, and with two synchronizer stages. The strap is tied to 101. With a 64-byte array, a four-byte write started at 0x3E crosses the top of the array, and a sequential read wraps back to 0 within a few bytes. The word address also carries set bits above bit 5, which tests that only the low ADDR_W bits are kept. The bus is driven at 40 system clocks per bit, so the edge-detection and register latency stays well inside each clock-line phase.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT
  } twi_phase_e;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  // Address byte selects this slave: prefix in [7:4], strap in [3:1].
  function automatic logic dev_select(input logic [7:0] abyte, input logic [2:0] strap);
    return (abyte[7:4] == DEV_PREFIX) && (abyte[3:1] == strap);
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_pipe, sda_pipe;
  logic          scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
      sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
      scl_q    <= scl_pipe[LAST];
      sda_q    <= sda_pipe[LAST];
    end
  end

  assign scl_o      = scl_pipe[LAST];
  assign sda_o      = sda_pipe[LAST];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/twi_byte_array.sv
module twi_byte_array #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cells[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/twi_proto.sv
module twi_proto
  import twi_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [2:0]        strap,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  twi_phase_e        ph;
  logic [3:0]        bitcnt;
  logic [7:0]        rx_sr, tx_sr, ahi;
  logic [ADDR_W-1:0] ptr;
  logic              rw, m_ack;

  // Named events, brought out for the checks below.
  logic rx_phase, byte_in_done, ack_end, dev_hit, mid_read_bit;
  assign rx_phase     = (ph == PH_DEV) || (ph == PH_AHI) || (ph == PH_ALO) || (ph == PH_WDAT);
  assign byte_in_done = scl_fall && rx_phase && (bitcnt == 4'd8);
  assign ack_end      = scl_fall && (ph != PH_IDLE) && (bitcnt == 4'd9);
  assign dev_hit      = dev_select(rx_sr, strap);
  assign mid_read_bit = (bitcnt >= 4'd1) && (bitcnt <= 4'd7);
  assign rd_addr      = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      bitcnt  <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      ahi     <= '0;
      ptr     <= '0;
      rw      <= 1'b0;
      m_ack   <= 1'b0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_ev) begin
        ph     <= PH_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        ph     <= PH_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (ph != PH_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            if (rx_phase) rx_sr <= {rx_sr[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
            if (ph == PH_RDAT) m_ack <= ~sda_s;
          end
        end else if (scl_fall) begin
          if (byte_in_done) begin
            case (ph)
              PH_DEV: begin
                if (dev_hit) begin
                  sda_oe <= 1'b1;
                  rw     <= rx_sr[0];
                end else begin
                  ph <= PH_IDLE;
                end
              end
              PH_AHI: begin
                ahi    <= rx_sr;
                sda_oe <= 1'b1;
              end
              PH_ALO: begin
                ptr    <= ADDR_W'({ahi, rx_sr});
                sda_oe <= 1'b1;
              end
              default: begin
                wr_stb  <= 1'b1;
                wr_addr <= ptr;
                wr_data <= rx_sr;
                ptr     <= ptr + 1'b1;
                sda_oe  <= 1'b1;
              end
            endcase
          end else if (ph == PH_RDAT && bitcnt == 4'd8) begin
            sda_oe <= 1'b0;
            ptr    <= ptr + 1'b1;
          end else if (ph == PH_RDAT && mid_read_bit) begin
            sda_oe <= ~tx_sr[7];
            tx_sr  <= {tx_sr[6:0], 1'b0};
          end else if (ack_end) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            case (ph)
              PH_DEV: begin
                if (rw) begin
                  ph     <= PH_RDAT;
                  tx_sr  <= {rd_data[6:0], 1'b0};
                  sda_oe <= ~rd_data[7];
                end else begin
                  ph <= PH_AHI;
                end
              end
              PH_AHI: ph <= PH_ALO;
              PH_ALO: ph <= PH_WDAT;
              PH_RDAT: begin
                if (m_ack) begin
                  tx_sr  <= {rd_data[6:0], 1'b0};
                  sda_oe <= ~rd_data[7];
                end else begin
                  ph <= PH_IDLE;
                end
              end
              default: ph <= ph;
            endcase
          end
        end
      end
    end
  end

  assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (ph == PH_DEV && bitcnt == 4'd0 && !sda_oe));
  assert_stop_idles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (ph == PH_IDLE && !sda_oe && !wr_stb));
  assert_mismatch_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_in_done && ph == PH_DEV && !dev_hit) |=> (ph == PH_IDLE && !sda_oe));
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_ptr_follows_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (ptr == ADDR_W'(wr_addr + 1'b1)));
  assert_nack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_end && ph == PH_RDAT && !m_ack && !start_ev && !stop_ev) |=> (ph == PH_IDLE && !sda_oe));
  assert_oe_quiet_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));
endmodule

// File: rtl/twi_byte_slave.sv
module twi_byte_slave #(
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  twi_proto #(.ADDR_W(ADDR_W)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .strap(strap_i), .rd_data(rd_data), .rd_addr(rd_addr), .sda_oe(sda_oe_o),
    .wr_stb(wr_stb_o), .wr_addr(wr_addr_o), .wr_data(wr_data_o)
  );

  twi_byte_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(wr_stb_o), .waddr(wr_addr_o), .wdata(wr_data_o),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: tb/twi_byte_slave_test.sv
module twi_byte_slave_test;
  localparam int AW = 6;
  localparam int Q  = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = 8'hAA, DEV_R = 8'hAB, DEV_BAD = 8'hA2;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_stb;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  wire sda_bus = sda_m & ~sda_oe;

  int total = 0, bad = 0, r10_viol = 0;
  bit done = 0;
  logic [7:0] model [64];
  logic [13:0] wq [$];
  logic scl_prev = 1'b1, oe_prev = 1'b0;

  always #5 clk = ~clk;

  twi_byte_slave #(.ADDR_W(AW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(STRAP),
    .sda_oe_o(sda_oe), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected strobes (R5, R11) and flags unexpected ones.
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (wq.size() == 0) chk(0, "R2/R4 unexpected strobe", {wr_addr, wr_data}, 0);
      else begin
        logic [13:0] e;
        e = wq.pop_front();
        chk({wr_addr, wr_data} == e, "R5/R11 write strobe", {wr_addr, wr_data}, e);
      end
    end
    if (rst_n && scl && scl_prev && sda_oe != oe_prev) r10_viol++;
    scl_prev <= scl;
    oe_prev  <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    scl = 0; tick(Q); sda_m = 1; tick(Q); scl = 1; tick(Q); sda_m = 0; tick(Q);
  endtask

  task automatic bus_stop();
    scl = 0; tick(Q); sda_m = 0; tick(Q); scl = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      scl = 0; tick(Q); sda_m = v[i]; tick(Q); scl = 1; tick(2 * Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    send_bits(v, 8);
    scl = 0; tick(Q); sda_m = 1; tick(Q); scl = 1; tick(Q);
    acked = ~sda_bus; tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      scl = 0; tick(Q); sda_m = 1; tick(Q); scl = 1; tick(Q); v[i] = sda_bus; tick(Q);
    end
    scl = 0; tick(Q); sda_m = ~give_ack; tick(Q); scl = 1; tick(2 * Q);
  endtask

  task automatic wr_expect(input logic [AW-1:0] a, input logic [7:0] d);
    wq.push_back({a, d});
    model[a] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] rd;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    tick(5);
    chk(sda_oe == 0, "reset oe", sda_oe, 0);
    chk(wr_stb == 0, "reset strobe", wr_stb, 0);
    rst_n = 1; tick(5);

    // Page of writes starting at 0x3E, high address bits discarded, wraps (R5, R3).
    bus_start();
    send_byte(DEV_W, ak); chk(ak, "R3 address ack", ak, 1);
    send_byte(8'h7F, ak); chk(ak, "R5 addr hi ack", ak, 1);
    send_byte(8'hFE, ak); chk(ak, "R5 addr lo ack", ak, 1);
    wr_expect(6'h3E, 8'h11); send_byte(8'h11, ak); chk(ak, "R5 data ack", ak, 1);
    wr_expect(6'h3F, 8'h22); send_byte(8'h22, ak); chk(ak, "R5 data ack", ak, 1);
    wr_expect(6'h00, 8'h33); send_byte(8'h33, ak); chk(ak, "R5 data ack", ak, 1);
    wr_expect(6'h01, 8'h44); send_byte(8'h44, ak); chk(ak, "R5 data ack", ak, 1);
    bus_stop();
    chk(wq.size() == 0, "R5 all strobes seen", wq.size(), 0);

    // Random read from 0x3E, sequential across the top (R7, R8, R11).
    bus_start();
    send_byte(DEV_W, ak); send_byte(8'h00, ak); send_byte(8'h3E, ak);
    bus_start();
    send_byte(DEV_R, ak); chk(ak, "R7 read address ack", ak, 1);
    recv_byte(1, rd); chk(rd == model[6'h3E], "R7 random read", rd, model[6'h3E]);
    recv_byte(1, rd); chk(rd == model[6'h3F], "R8 sequential", rd, model[6'h3F]);
    recv_byte(1, rd); chk(rd == model[6'h00], "R8 wrap to zero", rd, model[6'h00]);
    recv_byte(0, rd); chk(rd == model[6'h01], "R8 after wrap", rd, model[6'h01]);
    bus_stop();

    // Random read 0x3F, then current-address read gives 0x00 (R6), then NACK release (R9).
    bus_start();
    send_byte(DEV_W, ak); send_byte(8'h00, ak); send_byte(8'h3F, ak);
    bus_start(); send_byte(DEV_R, ak);
    recv_byte(0, rd); chk(rd == 8'h22, "R7 single random read", rd, 8'h22);
    bus_stop();
    bus_start(); send_byte(DEV_R, ak); chk(ak, "R6 ack", ak, 1);
    recv_byte(0, rd); chk(rd == 8'h33, "R6 current address", rd, 8'h33);
    chk(sda_oe == 0, "R9 released after nack", sda_oe, 0);
    recv_byte(0, rd); chk(rd == 8'hFF, "R9 silent after nack", rd, 8'hFF);
    bus_stop();

    // Mismatched address: no ack, following bytes ignored (R4).
    bus_start();
    send_byte(DEV_BAD, ak); chk(!ak, "R4 no ack on mismatch", ak, 0);
    send_byte(8'h00, ak); chk(!ak, "R4 later byte ignored", ak, 0);
    send_byte(8'h55, ak); chk(!ak, "R4 later byte ignored", ak, 0);
    bus_stop();

    // Start mid-byte restarts (R1); stop mid-data aborts write (R2).
    bus_start();
    send_bits(8'hA0, 4);
    bus_start();
    send_byte(DEV_W, ak); chk(ak, "R1 ack after restart", ak, 1);
    send_byte(8'h00, ak); send_byte(8'h10, ak);
    send_bits(8'hC3, 4);
    bus_stop();
    bus_start(); send_byte(DEV_R, ak);
    recv_byte(0, rd); chk(rd == model[6'h10], "R2 aborted byte not written", rd, model[6'h10]);
    bus_stop();
    tick(20);
    chk(wq.size() == 0, "R2 no pending strobes", wq.size(), 0);
    chk(r10_viol == 0, "R10 oe steady while scl high", r10_viol, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule